// File: doc/BRIEF.md
# Paged Bank Decoder with Shadowing

This block sits between a CPU with a 24-bit-style banked address space and a single byte-wide backing store that holds fast RAM, slow RAM and ROM. Each CPU address is resolved in two steps. The page number (the address above its low 8 bits) selects an entry in a page table, and that entry holds only a small region number. The region number then selects a descriptor. A descriptor holds separate read and write base offsets, a valid bit for each, and four attribute flags. The physical store address is the chosen base added to the whole CPU address, so one adder serves every page.

The attribute flags mark three kinds of region. In a shadowed region, a write is copied into one of two shadow banks as a second, costed store write. A slow region waits for an external slow-clock enable before it touches the store. An I/O region skips the store and signals an external I/O decoder instead. Software, or a boot sequencer, fills both tables through a synchronous configuration port. Region 0 is the permanent unmapped region.

The address width, store width, data width, region count and shadow bank number are parameters. The defaults are a 20-bit CPU address (16 banks of 64 KB, 4096 pages), a 20-bit store address and 16 regions.

Top module: `bank_decoder`

## Requirements
- R1: The page index is `cpu_addr[ADDR_W-1:8]`, and the region it selects supplies the bases. A read accesses `rd_base + cpu_addr` and a write accesses `wr_base + cpu_addr`, both modulo 2^PHYS_W. The read and write bases of one region may differ.
- R2: A `cpu_req` pulse is taken only while the block is idle. `cpu_ready` is a one-cycle pulse, and `cpu_rdata` is valid while it is high. If the request is sampled at edge k, `cpu_ready` rises after edge k+3 for a store read, after edge k+1 for an unshadowed write, and after edge k+1 for a read that returns 0xFF.
- R3: Region 0 never reaches the store. Reads through it return 0xFF, and writes through it cause no store access. A configuration write to descriptor index 0 is ignored.
- R4: A read in a region whose read-valid bit is clear returns 0xFF. A write in a region whose write-valid bit is clear is dropped. This is how ROM regions are built.
- R5: Flag bit 0 (lower shadow) or flag bit 1 (upper shadow) in the request's region adds a second store write. It carries the same data and the same low 16 address bits, and goes into bank SHADOW_HI_BANK minus flag bit 0: bank 0xC when bit 0 is set, bank 0xD when only bit 1 is set (default parameters). The second write's region is looked up again through the page table, and the write is dropped if that region is not writable. `cpu_ready` comes one cycle later than for an unshadowed write. The second write is never stalled.
- R6: For a region with flag bit 2 (slow), the block makes no store access, raises no `io_hit` and gives no `cpu_ready` until `slow_tick` is sampled high in the lookup or wait state.
- R7: For a region with flag bit 3 (I/O), `io_hit` pulses for one cycle with `io_addr` equal to the CPU address and `io_we` equal to the request direction, and the store is not accessed. A read returns `io_rdata` as sampled in the `io_hit` cycle.
- R8: A configuration write takes effect at the clock edge. A lookup that samples the table at that same edge uses the old contents.
- R9: After reset, `cpu_ready`, `mem_en` and `io_hit` are low and every descriptor is invalid with clear flags, so every read returns 0xFF.
- R10: `mem_we` is high only together with `mem_en`. Store read data is taken one cycle after the cycle in which `mem_en` is presented with `mem_we` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request strobe, taken while idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | CPU address (bank and offset) |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| slow_tick | input | 1 | Slow-clock enable pulse |
| mem_en | output | 1 | Store access strobe |
| mem_we | output | 1 | Store write |
| mem_addr | output | PHYS_W | Store address |
| mem_wdata | output | DATA_W | Store write data |
| mem_rdata | input | DATA_W | Store read data, one cycle after mem_en |
| io_hit | output | 1 | I/O region access pulse |
| io_we | output | 1 | Direction of the I/O access |
| io_addr | output | ADDR_W | Address of the I/O access |
| io_rdata | input | DATA_W | Data returned by the I/O decoder |
| cfg_page_we | input | 1 | Page table write strobe |
| cfg_page | input | ADDR_W-8 | Page table index |
| cfg_page_region | input | $clog2(REGIONS) | Region number to store |
| cfg_desc_we | input | 1 | Descriptor write strobe |
| cfg_desc_idx | input | $clog2(REGIONS) | Descriptor index |
| cfg_rd_ok | input | 1 | Read-valid bit |
| cfg_wr_ok | input | 1 | Write-valid bit |
| cfg_rd_base | input | PHYS_W | Read base offset |
| cfg_wr_base | input | PHYS_W | Write base offset |
| cfg_flags | input | 4 | Flags: 0 lower shadow, 1 upper shadow, 2 slow, 3 I/O |

## Verification
A wrong page-table or descriptor entry appears at the next access to that page. It shows as a wrong `mem_addr`, a 0xFF read where data was expected, or a store access where `io_hit` should have fired, and it is seen within three cycles of the request. A wrong shadow-bank choice appears only on the second write, one cycle after the first, as a store address in the wrong bank. The randomized mix checks every store write's address and data against a model that the bench computes from its own copy of the tables. A state machine that skips the slow wait shows as store activity before the slow-clock pulse is given.

// File: rtl/bank_dec_pkg.sv
package bank_dec_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WAIT,
    ST_RDWAIT,
    ST_RDCAP,
    ST_IO,
    ST_SHADOW
  } dec_state_e;

  localparam int FL_SH_LO = 0;
  localparam int FL_SH_HI = 1;
  localparam int FL_SLOW  = 2;
  localparam int FL_IO    = 3;
  localparam int FL_W     = 4;
endpackage

// File: rtl/bank_dec_page_table.sv
module bank_dec_page_table #(
  parameter int IDX_W = 12,
  parameter int REG_W = 4
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [REG_W-1:0] wr_val,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [REG_W-1:0] rd_val
);
  localparam int DEPTH = 1 << IDX_W;

  logic [REG_W-1:0] tbl [DEPTH];

  // Write port and read port are separate, so a read at the same edge returns the old entry.
  always_ff @(posedge clk) begin
    if (wr_en) tbl[wr_idx] <= wr_val;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_val <= tbl[rd_idx];
  end
endmodule

// File: rtl/bank_dec_region_file.sv
module bank_dec_region_file
  import bank_dec_pkg::*;
#(
  parameter int REGIONS = 16,
  parameter int PHYS_W  = 20,
  parameter int REG_W   = $clog2(REGIONS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_idx,
  input  logic              wr_rd_ok,
  input  logic              wr_wr_ok,
  input  logic [PHYS_W-1:0] wr_rd_base,
  input  logic [PHYS_W-1:0] wr_wr_base,
  input  logic [FL_W-1:0]   wr_flags,
  input  logic [REG_W-1:0]  rd_idx,
  output logic              rd_rd_ok,
  output logic              rd_wr_ok,
  output logic [PHYS_W-1:0] rd_rd_base,
  output logic [PHYS_W-1:0] rd_wr_base,
  output logic [FL_W-1:0]   rd_flags
);
  typedef struct packed {
    logic              rd_ok;
    logic              wr_ok;
    logic [PHYS_W-1:0] rd_base;
    logic [PHYS_W-1:0] wr_base;
    logic [FL_W-1:0]   flags;
  } desc_t;

  desc_t ent [REGIONS];
  desc_t sel;

  // Index 0 is the unmapped region: it is never written, so it keeps its reset value.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REGIONS; i++) ent[i] <= '0;
    end else if (wr_en && (wr_idx != '0) && (int'(wr_idx) < REGIONS)) begin
      ent[wr_idx] <= '{rd_ok: wr_rd_ok, wr_ok: wr_wr_ok, rd_base: wr_rd_base,
                       wr_base: wr_wr_base, flags: wr_flags};
    end
  end

  always_comb begin
    sel = '0;
    if (int'(rd_idx) < REGIONS) sel = ent[rd_idx];
  end

  assign rd_rd_ok   = sel.rd_ok;
  assign rd_wr_ok   = sel.wr_ok;
  assign rd_rd_base = sel.rd_base;
  assign rd_wr_base = sel.wr_base;
  assign rd_flags   = sel.flags;
endmodule

// File: rtl/bank_decoder.sv
module bank_decoder
  import bank_dec_pkg::*;
#(
  parameter int ADDR_W         = 20,
  parameter int PHYS_W         = 20,
  parameter int DATA_W         = 8,
  parameter int REGIONS        = 16,
  parameter int SHADOW_HI_BANK = 'hD
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cpu_req,
  input  logic                       cpu_we,
  input  logic [ADDR_W-1:0]          cpu_addr,
  input  logic [DATA_W-1:0]          cpu_wdata,
  output logic [DATA_W-1:0]          cpu_rdata,
  output logic                       cpu_ready,
  input  logic                       slow_tick,
  output logic                       mem_en,
  output logic                       mem_we,
  output logic [PHYS_W-1:0]          mem_addr,
  output logic [DATA_W-1:0]          mem_wdata,
  input  logic [DATA_W-1:0]          mem_rdata,
  output logic                       io_hit,
  output logic                       io_we,
  output logic [ADDR_W-1:0]          io_addr,
  input  logic [DATA_W-1:0]          io_rdata,
  input  logic                       cfg_page_we,
  input  logic [ADDR_W-9:0]          cfg_page,
  input  logic [$clog2(REGIONS)-1:0] cfg_page_region,
  input  logic                       cfg_desc_we,
  input  logic [$clog2(REGIONS)-1:0] cfg_desc_idx,
  input  logic                       cfg_rd_ok,
  input  logic                       cfg_wr_ok,
  input  logic [PHYS_W-1:0]          cfg_rd_base,
  input  logic [PHYS_W-1:0]          cfg_wr_base,
  input  logic [3:0]                 cfg_flags
);
  localparam int PAGE_W = ADDR_W - 8;
  localparam int BANK_W = ADDR_W - 16;
  localparam int REG_W  = $clog2(REGIONS);
  localparam logic [DATA_W-1:0] OPEN_BUS = '1;

  dec_state_e        st;
  logic [ADDR_W-1:0] a_q;
  logic              we_q;
  logic [DATA_W-1:0] wd_q;
  logic [BANK_W-1:0] shb_q;

  logic [REG_W-1:0]  pt_q;
  logic              pt_rd_en;
  logic [PAGE_W-1:0] pt_rd_idx;

  logic              d_rd_ok, d_wr_ok;
  logic [PHYS_W-1:0] d_rd_base, d_wr_base;
  logic [FL_W-1:0]   d_flags;

  logic              in_look, go, slow_hold, shadow_any, null_region;
  logic [BANK_W-1:0] sh_bank;
  logic [PHYS_W-1:0] addr_ext, shadow_ext;

  bank_dec_page_table #(.IDX_W(PAGE_W), .REG_W(REG_W)) u_pt (
    .clk    (clk),
    .wr_en  (cfg_page_we),
    .wr_idx (cfg_page),
    .wr_val (cfg_page_region),
    .rd_en  (pt_rd_en),
    .rd_idx (pt_rd_idx),
    .rd_val (pt_q)
  );

  bank_dec_region_file #(.REGIONS(REGIONS), .PHYS_W(PHYS_W), .REG_W(REG_W)) u_rf (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (cfg_desc_we),
    .wr_idx     (cfg_desc_idx),
    .wr_rd_ok   (cfg_rd_ok),
    .wr_wr_ok   (cfg_wr_ok),
    .wr_rd_base (cfg_rd_base),
    .wr_wr_base (cfg_wr_base),
    .wr_flags   (cfg_flags),
    .rd_idx     (pt_q),
    .rd_rd_ok   (d_rd_ok),
    .rd_wr_ok   (d_wr_ok),
    .rd_rd_base (d_rd_base),
    .rd_wr_base (d_wr_base),
    .rd_flags   (d_flags)
  );

  assign in_look     = (st == ST_LOOK) || (st == ST_WAIT);
  assign go          = in_look && (!d_flags[FL_SLOW] || slow_tick);
  assign slow_hold   = in_look && d_flags[FL_SLOW] && !slow_tick;
  assign shadow_any  = d_flags[FL_SH_LO] | d_flags[FL_SH_HI];
  assign sh_bank     = BANK_W'(SHADOW_HI_BANK) - BANK_W'(d_flags[FL_SH_LO]);
  assign null_region = (pt_q == '0);
  assign addr_ext    = PHYS_W'(a_q);
  assign shadow_ext  = PHYS_W'({shb_q, a_q[15:0]});

  // The page table is read when a request is taken, and again for the shadow target page.
  assign pt_rd_en  = ((st == ST_IDLE) && cpu_req) ||
                     (go && we_q && shadow_any && !d_flags[FL_IO]);
  assign pt_rd_idx = (st == ST_IDLE) ? cpu_addr[ADDR_W-1:8] : {sh_bank, a_q[15:8]};

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      a_q       <= '0;
      we_q      <= 1'b0;
      wd_q      <= '0;
      shb_q     <= '0;
      cpu_ready <= 1'b0;
      cpu_rdata <= '0;
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      io_hit    <= 1'b0;
      io_we     <= 1'b0;
      io_addr   <= '0;
    end else begin
      cpu_ready <= 1'b0;
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      io_hit    <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (cpu_req) begin
            a_q  <= cpu_addr;
            we_q <= cpu_we;
            wd_q <= cpu_wdata;
            st   <= ST_LOOK;
          end
        end
        ST_LOOK, ST_WAIT: begin
          if (!go) begin
            st <= ST_WAIT;
          end else if (d_flags[FL_IO]) begin
            io_hit  <= 1'b1;
            io_we   <= we_q;
            io_addr <= a_q;
            st      <= ST_IO;
          end else if (!we_q) begin
            if (d_rd_ok) begin
              mem_en   <= 1'b1;
              mem_addr <= d_rd_base + addr_ext;
              st       <= ST_RDWAIT;
            end else begin
              cpu_rdata <= OPEN_BUS;
              cpu_ready <= 1'b1;
              st        <= ST_IDLE;
            end
          end else begin
            if (d_wr_ok) begin
              mem_en    <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= d_wr_base + addr_ext;
              mem_wdata <= wd_q;
            end
            if (shadow_any) begin
              shb_q <= sh_bank;
              st    <= ST_SHADOW;
            end else begin
              cpu_ready <= 1'b1;
              st        <= ST_IDLE;
            end
          end
        end
        ST_RDWAIT: st <= ST_RDCAP;
        ST_RDCAP: begin
          cpu_rdata <= mem_rdata;
          cpu_ready <= 1'b1;
          st        <= ST_IDLE;
        end
        ST_IO: begin
          if (!we_q) cpu_rdata <= io_rdata;
          cpu_ready <= 1'b1;
          st        <= ST_IDLE;
        end
        ST_SHADOW: begin
          if (d_wr_ok) begin
            mem_en    <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= d_wr_base + shadow_ext;
            mem_wdata <= wd_q;
          end
          cpu_ready <= 1'b1;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bank_decoder_chk.sv
module bank_decoder_chk (
  input logic clk,
  input logic rst,
  input logic cpu_ready,
  input logic mem_en,
  input logic mem_we,
  input logic io_hit,
  input logic slow_hold,
  input logic go,
  input logic null_region
);
  // R2: completion is a single-cycle pulse
  a_r2_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  // R7: an I/O access never reaches the store
  a_r7_io_no_store: assert property (@(posedge clk) disable iff (rst)
    io_hit |-> !mem_en);

  // R6: while waiting for the slow enable nothing happens
  a_r6_slow_hold: assert property (@(posedge clk) disable iff (rst)
    slow_hold |=> (!cpu_ready && !mem_en && !io_hit));

  // R3: region 0 resolves with no store or I/O activity
  a_r3_null_quiet: assert property (@(posedge clk) disable iff (rst)
    (go && null_region) |=> (!mem_en && !io_hit));

  // R10: a store write always comes with the access strobe
  a_r10_we_with_en: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_en);
endmodule

bind bank_decoder bank_decoder_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .cpu_ready   (cpu_ready),
  .mem_en      (mem_en),
  .mem_we      (mem_we),
  .io_hit      (io_hit),
  .slow_hold   (slow_hold),
  .go          (go),
  .null_region (null_region)
);

// File: tb/tb_bank_decoder.sv
`timescale 1ns/1ps
module tb_bank_decoder;
  localparam int AW = 20;
  localparam int PW = 20;
  localparam int DW = 8;
  localparam int RG = 16;

  logic clk = 1'b0;
  logic rst;
  logic cpu_req, cpu_we;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata;
  logic cpu_ready, slow_tick;
  logic mem_en, mem_we;
  logic [PW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic io_hit, io_we;
  logic [AW-1:0] io_addr;
  logic [DW-1:0] io_rdata;
  logic cfg_page_we;
  logic [AW-9:0] cfg_page;
  logic [3:0] cfg_page_region;
  logic cfg_desc_we;
  logic [3:0] cfg_desc_idx;
  logic cfg_rd_ok, cfg_wr_ok;
  logic [PW-1:0] cfg_rd_base, cfg_wr_base;
  logic [3:0] cfg_flags;

  always #2 clk = ~clk;

  bank_decoder dut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .slow_tick(slow_tick), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .io_hit(io_hit), .io_we(io_we),
    .io_addr(io_addr), .io_rdata(io_rdata), .cfg_page_we(cfg_page_we),
    .cfg_page(cfg_page), .cfg_page_region(cfg_page_region), .cfg_desc_we(cfg_desc_we),
    .cfg_desc_idx(cfg_desc_idx), .cfg_rd_ok(cfg_rd_ok), .cfg_wr_ok(cfg_wr_ok),
    .cfg_rd_base(cfg_rd_base), .cfg_wr_base(cfg_wr_base), .cfg_flags(cfg_flags)
  );

  // Bench copy of the configuration
  logic [3:0]    ptab  [4096];
  logic          m_rok [RG];
  logic          m_wok [RG];
  logic [PW-1:0] m_rb  [RG];
  logic [PW-1:0] m_wb  [RG];
  logic [3:0]    m_fl  [RG];
  logic [7:0]    store [int];

  int n_cmp = 0, n_bad = 0;
  int n_mem, n_wr, n_io, pre_tick_mem;
  bit tick_given;
  logic [PW-1:0] wlog_a [4];
  logic [7:0]    wlog_d [4];
  logic [AW-1:0] io_addr_seen;
  logic          io_we_seen;

  function automatic logic [7:0] mval(input logic [PW-1:0] pa);
    if (store.exists(int'(pa))) return store[int'(pa)];
    return pa[7:0] ^ pa[15:8] ^ 8'h5A;
  endfunction

  // Backing store model and port monitor
  always @(posedge clk) begin
    if (mem_en) begin
      n_mem++;
      if (!tick_given) pre_tick_mem++;
      if (mem_we) begin
        if (n_wr < 4) begin
          wlog_a[n_wr] = mem_addr;
          wlog_d[n_wr] = mem_wdata;
        end
        n_wr++;
        store[int'(mem_addr)] = mem_wdata;
      end else begin
        mem_rdata <= mval(mem_addr);
      end
    end
    if (io_hit) begin
      n_io++;
      io_addr_seen = io_addr;
      io_we_seen   = io_we;
    end
    if (slow_tick) tick_given = 1'b1;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  task automatic set_page(input int p, input logic [3:0] r);
    cfg_page_we = 1'b1; cfg_page = 12'(p); cfg_page_region = r;
    @(negedge clk);
    cfg_page_we = 1'b0;
    ptab[p] = r;
  endtask

  task automatic set_desc(input logic [3:0] i, input logic ro, input logic wo,
                          input logic [PW-1:0] rb, input logic [PW-1:0] wb, input logic [3:0] fl);
    cfg_desc_we = 1'b1; cfg_desc_idx = i; cfg_rd_ok = ro; cfg_wr_ok = wo;
    cfg_rd_base = rb; cfg_wr_base = wb; cfg_flags = fl;
    @(negedge clk);
    cfg_desc_we = 1'b0;
    if (i != 0) begin  // R3: index 0 keeps no configuration
      m_rok[i] = ro; m_wok[i] = wo; m_rb[i] = rb; m_wb[i] = wb; m_fl[i] = fl;
    end
  endtask

  // Issue one access; slow_tick is pulsed once if no completion by the 8th wait cycle.
  task automatic access(input logic we, input logic [AW-1:0] a, input logic [7:0] wd,
                        output logic [7:0] rd, output int lat);
    n_mem = 0; n_wr = 0; n_io = 0; pre_tick_mem = 0; tick_given = 1'b0;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
    lat = 1;
    while (!cpu_ready && lat < 60) begin
      if (lat == 8) slow_tick = 1'b1;
      @(negedge clk);
      slow_tick = 1'b0;
      lat++;
    end
    if (!cpu_ready) chk("R2", "completion timeout", 32'd0, 32'd1);
    rd = cpu_rdata;
    @(negedge clk);
  endtask

  function automatic logic [7:0] exp_read(input logic [AW-1:0] a);
    logic [3:0] r;
    r = ptab[a[19:8]];
    if (m_fl[r][3]) return io_rdata;
    if (!m_rok[r]) return 8'hFF;
    return mval(m_rb[r] + PW'(a));
  endfunction

  task automatic exp_write(input logic [AW-1:0] a, output int n,
                           output logic [PW-1:0] a0, output logic [PW-1:0] a1);
    logic [3:0] r, r2;
    logic [AW-1:0] sa;
    n = 0; a0 = '0; a1 = '0;
    r = ptab[a[19:8]];
    if (m_fl[r][3]) return;
    if (m_wok[r]) begin a0 = m_wb[r] + PW'(a); n++; end
    if (m_fl[r][1:0] != 2'b00) begin
      sa = {4'hD - {3'b0, m_fl[r][0]}, a[15:0]};
      r2 = ptab[sa[19:8]];
      if (m_wok[r2]) begin
        if (n == 0) a0 = m_wb[r2] + PW'(sa); else a1 = m_wb[r2] + PW'(sa);
        n++;
      end
    end
  endtask

  function automatic logic [3:0] region_for(input int p);
    int b;
    b = p >> 8;
    case (b)
      0: return 4'd1;
      1: return ((p & 8'hFF) < 8'h80) ? 4'd2 : 4'd3;
      2: return ((p & 8'hF0) == 8'hC0) ? 4'd6 : 4'd1;
      3: return 4'd8;
      12: return 4'd4;
      13: return 4'd5;
      15: return 4'd7;
      default: return 4'd0;
    endcase
  endfunction

  initial begin
    logic [7:0] rd;
    int lat, en;
    logic [PW-1:0] ea0, ea1;
    logic [3:0] banks [9];
    banks = '{4'h0, 4'h1, 4'h2, 4'h3, 4'hC, 4'hD, 4'hF, 4'h5, 4'hE};
    void'($urandom(32'd20240611));
    for (int i = 0; i < RG; i++) begin
      m_rok[i] = 0; m_wok[i] = 0; m_rb[i] = '0; m_wb[i] = '0; m_fl[i] = '0;
    end
    rst = 1'b1; cpu_req = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0; slow_tick = 0;
    io_rdata = '0; cfg_page_we = 0; cfg_page = '0; cfg_page_region = '0; cfg_desc_we = 0;
    cfg_desc_idx = '0; cfg_rd_ok = 0; cfg_wr_ok = 0; cfg_rd_base = '0; cfg_wr_base = '0;
    cfg_flags = '0; mem_rdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9", "cpu_ready after reset", 32'(cpu_ready), 32'd0);
    chk("R9", "mem_en after reset", 32'(mem_en), 32'd0);
    chk("R9", "io_hit after reset", 32'(io_hit), 32'd0);
    access(1'b0, 20'h00123, 8'h00, rd, lat);
    chk("R9", "read with empty descriptors", 32'(rd), 32'hFF);

    // R3: descriptor 0 cannot be made valid
    set_desc(4'd0, 1'b1, 1'b1, '0, '0, 4'b0000);
    for (int p = 0; p < 4096; p++) set_page(p, region_for(p));
    set_desc(4'd1, 1, 1, 20'h00000, 20'h00000, 4'b0000);
    set_desc(4'd2, 1, 1, 20'h00000, 20'h00000, 4'b0010);
    set_desc(4'd3, 1, 1, 20'h00000, 20'h00000, 4'b0011);
    set_desc(4'd4, 1, 1, 20'h20000, 20'h20000, 4'b0100);
    set_desc(4'd5, 1, 1, 20'h20000, 20'h20000, 4'b0100);
    set_desc(4'd6, 0, 0, 20'h00000, 20'h00000, 4'b1000);
    set_desc(4'd7, 1, 0, 20'h40000, 20'h00000, 4'b0000);
    set_desc(4'd8, 1, 1, 20'h10000, 20'h50000, 4'b0000);

    // R3: unmapped region
    access(1'b0, 20'h50077, 8'h00, rd, lat);
    chk("R3", "unmapped read data", 32'(rd), 32'hFF);
    chk("R3", "unmapped read store accesses", 32'(n_mem), 32'd0);
    access(1'b1, 20'h50078, 8'h99, rd, lat);
    chk("R3", "unmapped write store accesses", 32'(n_mem), 32'd0);

    // R2 / R10: fast write then read back, with latencies
    access(1'b1, 20'h00040, 8'h3C, rd, lat);
    chk("R2", "write latency", 32'(lat), 32'd2);
    chk("R1", "write address", 32'(wlog_a[0]), 32'h00040);
    access(1'b0, 20'h00040, 8'h00, rd, lat);
    chk("R2", "read latency", 32'(lat), 32'd4);
    chk("R10", "read-back data", 32'(rd), 32'h3C);

    // R1: distinct read and write bases
    access(1'b1, 20'h31234, 8'h77, rd, lat);
    chk("R1", "write base applied", 32'(wlog_a[0]), 32'h81234);
    access(1'b0, 20'h31234, 8'h00, rd, lat);
    chk("R1", "read base applied", 32'(rd), 32'(mval(20'h41234)));

    // R4: ROM bank
    access(1'b0, 20'hF0010, 8'h00, rd, lat);
    chk("R4", "rom read", 32'(rd), 32'(mval(20'h30010)));
    access(1'b1, 20'hF0010, 8'hEE, rd, lat);
    chk("R4", "rom write dropped", 32'(n_mem), 32'd0);
    access(1'b0, 20'hF0010, 8'h00, rd, lat);
    chk("R4", "rom unchanged", 32'(rd), 32'(mval(20'h30010)));

    // R5: shadow writes
    access(1'b1, 20'h10020, 8'h11, rd, lat);
    chk("R5", "upper shadow write count", 32'(n_wr), 32'd2);
    chk("R5", "upper shadow primary", 32'(wlog_a[0]), 32'h10020);
    chk("R5", "upper shadow copy", 32'(wlog_a[1]), 32'hF0020);
    chk("R5", "upper shadow data", 32'(wlog_d[1]), 32'h11);
    chk("R5", "shadow latency", 32'(lat), 32'd3);
    access(1'b1, 20'h18030, 8'h22, rd, lat);
    chk("R5", "lower shadow copy", 32'(wlog_a[1]), 32'hE8030);

    // R6: slow region waits for the enable
    access(1'b0, 20'hC0100, 8'h00, rd, lat);
    chk("R6", "store access before tick", 32'(pre_tick_mem), 32'd0);
    chk("R6", "ready after tick", 32'(lat > 8), 32'd1);
    chk("R6", "slow read data", 32'(rd), 32'(mval(20'hE0100)));

    // R7: I/O region
    io_rdata = 8'hA7;
    access(1'b0, 20'h2C055, 8'h00, rd, lat);
    chk("R7", "io read data", 32'(rd), 32'hA7);
    chk("R7", "io store accesses", 32'(n_mem), 32'd0);
    chk("R7", "io_hit count", 32'(n_io), 32'd1);
    chk("R7", "io address", 32'(io_addr_seen), 32'h2C055);
    access(1'b1, 20'h2C056, 8'h5E, rd, lat);
    chk("R7", "io write bypass", 32'(n_mem), 32'd0);
    chk("R7", "io write direction", 32'(io_we_seen), 32'd1);

    // R8: configuration write at the same edge as the lookup
    cfg_page_we = 1'b1; cfg_page = 12'hE00; cfg_page_region = 4'd1;
    access(1'b0, 20'hE0010, 8'h00, rd, lat);
    cfg_page_we = 1'b0;
    ptab[12'hE00] = 4'd1;
    chk("R8", "same-edge lookup uses old entry", 32'(rd), 32'hFF);
    access(1'b0, 20'hE0010, 8'h00, rd, lat);
    chk("R8", "later lookup uses new entry", 32'(rd), 32'(mval(20'hE0010)));

    // Random mix
    for (int k = 0; k < 300; k++) begin
      logic [3:0] b;
      logic [15:0] off;
      logic [AW-1:0] a;
      logic w;
      logic [7:0] d, er;
      b = banks[$urandom_range(0, 8)];
      off = 16'($urandom);
      if (b == 4'h2 && $urandom_range(0, 3) == 0) off[15:12] = 4'hC;
      a = {b, off};
      w = 1'($urandom_range(0, 1));
      d = 8'($urandom);
      io_rdata = 8'($urandom);
      if (w) begin
        exp_write(a, en, ea0, ea1);
        access(1'b1, a, d, rd, lat);
        chk("R5", "random write count", 32'(n_wr), 32'(en));
        if (en > 0) chk("R1", "random write addr", 32'(wlog_a[0]), 32'(ea0));
        if (en > 1) chk("R5", "random shadow addr", 32'(wlog_a[1]), 32'(ea1));
        if (en > 0) chk("R1", "random write data", 32'(wlog_d[0]), 32'(d));
      end else begin
        er = exp_read(a);
        access(1'b0, a, 8'h00, rd, lat);
        chk("R4", "random read data", 32'(rd), 32'(er));
      end
    end

    summary();
    $finish;
  end
endmodule